// File: doc/BRIEF.md
# Self-Refresh Scheduler with Latency Flag

This block sits on the device side of a pseudo-static DRAM and keeps the periodic refresh of the dynamic array out of the host's view. A free-running interval timer marks a refresh as owed at a fixed spacing. The scheduler hands owed refreshes to the array core through a request/acknowledge pair, but it starts one only while chip select is high. A refresh therefore never cuts into a read or write burst.

When the host opens a transaction while a refresh is still owed, the block raises a latency flag. That flag is driven on the strobe line for the whole command/address phase. It tells the host that the initial access latency is doubled, so the owed refresh can run before data moves. The block also reports the doubled or single initial latency count to the data-path timing logic.

A deadline watchdog sets a sticky error if an owed refresh stays outstanding for more than a programmable number of cycles. This happens when the host holds transactions open for too long.

Top module: `psram_refresh_sched`

## Requirements
- R1: After reset, `rf_req`, `txn_active`, `strobe_oe`, `lat_flag` and `deadline_err` are 0, and `init_lat` equals LAT_BASE.
- R2: A refresh becomes owed at every INTERVAL-th clock edge after reset. An owed refresh stays owed until the core acknowledges it. An interval expiry on the acknowledging edge leaves a refresh owed.
- R3: `rf_req` rises only after a clock edge that samples `cs_n` high while a refresh is owed. A refresh never begins inside a transaction.
- R4: Once raised, `rf_req` stays high until an edge samples `rf_ack` high, even if `cs_n` falls in the meantime. It is low in the cycle after that edge, and the owed refresh is cleared.
- R5: `strobe_oe` goes high in the cycle after the first edge that samples `cs_n` low. It stays high for exactly CA_CYCLES cycles, or it ends early after an edge that samples `cs_n` high.
- R6: `lat_flag` is high throughout the `strobe_oe` window if a refresh was owed just before the edge that opened the transaction. Otherwise it is low throughout that window. It is never high outside the window.
- R7: `init_lat` equals 2*LAT_BASE while the current transaction was flagged, and LAT_BASE otherwise. It returns to LAT_BASE after an edge that samples `cs_n` high.
- R8: `deadline_err` is set after an edge at which a refresh has been owed for more than `max_wait` cycles. The first owed cycle counts as zero. The error stays set until reset.
- R9: `txn_active` is the value of `cs_n` sampled low at the previous edge. It is 1 while the transaction is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Host chip select, active low; low marks an open transaction |
| max_wait | input | WAIT_W | Longest allowed outstanding time for an owed refresh, in cycles |
| rf_ack | input | 1 | Core signals the refresh cycle is complete |
| rf_req | output | 1 | Request to the core to run one refresh cycle |
| txn_active | output | 1 | Registered transaction-open indication |
| strobe_oe | output | 1 | Strobe line is driven by the device (command/address phase) |
| lat_flag | output | 1 | Value driven on the strobe line: 1 requests doubled initial latency |
| init_lat | output | LW | Initial latency count for the current transaction |
| deadline_err | output | 1 | Sticky refresh deadline violation |

## Verification
The bench builds the block with INTERVAL=20, CA_CYCLES=3, LAT_BASE=6 and WAIT_W=8. The short interval makes refreshes come due many times in a short run, so they land in idle gaps, inside transactions, and at chip-select falling edges. Transactions of one and two cycles cut the three-cycle command/address window short. A bench model tracks the owed state cycle by cycle against a generous `max_wait` of 255. A `max_wait` of 4 and a long transaction then bring the deadline error and its stickiness within reach.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_RFSH = 1'b1
  } arb_state_t;

  // Initial latency in cycles: doubled when a refresh is owed at transaction start.
  function automatic int unsigned init_latency(input logic owed, input int unsigned base);
    return owed ? (2 * base) : base;
  endfunction

  // Saturating increment for a counter of the given width.
  function automatic int unsigned sat_inc(input int unsigned val, input int unsigned width);
    int unsigned top;
    top = (32'd1 << width) - 1;
    return (val >= top) ? top : val + 1;
  endfunction

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int unsigned INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rs_arbiter.sv
module rs_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cs_n,
  input  logic rf_ack,
  output logic rf_req,
  output logic pend,
  output logic rf_done
);
  import rs_pkg::*;

  arb_state_t state_q, state_d;
  logic       pend_q, pend_d;

  assign rf_req  = (state_q == ARB_RFSH);
  assign rf_done = rf_req && rf_ack;
  assign pend    = pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: if (pend_q && cs_n) state_d = ARB_RFSH;
      ARB_RFSH: if (rf_ack)         state_d = ARB_IDLE;
      default:                      state_d = ARB_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (tick)         pend_d = 1'b1;
    else if (rf_done) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/rs_ca_tracker.sv
module rs_ca_tracker #(
  parameter int unsigned CA_CYCLES = 3,
  parameter int unsigned LAT_BASE  = 6,
  localparam int unsigned CW = $clog2(CA_CYCLES + 1),
  localparam int unsigned LW = $clog2(2 * LAT_BASE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          pend,
  output logic          cs_fall,
  output logic          txn_active,
  output logic          strobe_oe,
  output logic          lat_flag,
  output logic [LW-1:0] init_lat
);
  logic          cs_q;
  logic [CW-1:0] ca_cnt_q;
  logic          hit_q;

  assign cs_fall    = cs_q && !cs_n;
  assign txn_active = !cs_q;
  assign strobe_oe  = (ca_cnt_q != '0);
  assign lat_flag   = strobe_oe && hit_q;
  assign init_lat   = LW'(rs_pkg::init_latency(hit_q, LAT_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      ca_cnt_q <= '0;
      hit_q    <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_fall) begin
        ca_cnt_q <= CW'(CA_CYCLES);
        hit_q    <= pend;
      end else if (cs_n) begin
        ca_cnt_q <= '0;
        hit_q    <= 1'b0;
      end else if (ca_cnt_q != '0) begin
        ca_cnt_q <= ca_cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_deadline.sv
module rs_deadline #(
  parameter int unsigned WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic [WAIT_W-1:0] max_wait,
  output logic              overdue,
  output logic              deadline_err
);
  logic [WAIT_W-1:0] age_q;
  logic              err_q;

  assign overdue      = pend && (age_q >= max_wait);
  assign deadline_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      err_q <= 1'b0;
    end else begin
      age_q <= pend ? WAIT_W'(rs_pkg::sat_inc(32'(age_q), WAIT_W)) : '0;
      if (overdue) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
  parameter int unsigned INTERVAL  = 1024,
  parameter int unsigned CA_CYCLES = 3,
  parameter int unsigned LAT_BASE  = 6,
  parameter int unsigned WAIT_W    = 8,
  localparam int unsigned LW = $clog2(2 * LAT_BASE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [WAIT_W-1:0] max_wait,
  input  logic              rf_ack,
  output logic              rf_req,
  output logic              txn_active,
  output logic              strobe_oe,
  output logic              lat_flag,
  output logic [LW-1:0]     init_lat,
  output logic              deadline_err
);
  logic tick_w;
  logic pend_w;
  logic rf_done_w;
  logic cs_fall_w;
  logic overdue_w;

  rs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_w)
  );

  rs_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .cs_n    (cs_n),
    .rf_ack  (rf_ack),
    .rf_req  (rf_req),
    .pend    (pend_w),
    .rf_done (rf_done_w)
  );

  rs_ca_tracker #(.CA_CYCLES(CA_CYCLES), .LAT_BASE(LAT_BASE)) u_ca (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .pend       (pend_w),
    .cs_fall    (cs_fall_w),
    .txn_active (txn_active),
    .strobe_oe  (strobe_oe),
    .lat_flag   (lat_flag),
    .init_lat   (init_lat)
  );

  rs_deadline #(.WAIT_W(WAIT_W)) u_dl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend         (pend_w),
    .max_wait     (max_wait),
    .overdue      (overdue_w),
    .deadline_err (deadline_err)
  );
endmodule

// File: rtl/psram_refresh_sched_chk.sv
module psram_refresh_sched_chk #(
  parameter int unsigned CA_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rf_ack,
  input logic rf_req,
  input logic txn_active,
  input logic strobe_oe,
  input logic lat_flag,
  input logic deadline_err,
  input logic pend,
  input logic rf_done,
  input logic cs_fall,
  input logic overdue
);
  localparam int unsigned RW = $clog2(CA_CYCLES + 2);
  logic [RW-1:0] oe_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run_q <= '0;
    end else begin
      oe_run_q <= strobe_oe ? oe_run_q + 1'b1 : '0;
      assert_ca_window_R5: assert (32'(oe_run_q) <= CA_CYCLES)
        else $error("command/address window longer than CA_CYCLES");
    end
  end

  assert_req_starts_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_req) |-> $past(cs_n));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && !rf_ack) |=> rf_req);

  assert_req_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_done |=> !rf_req);

  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(rf_done));

  assert_ca_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_oe) |-> $past(cs_fall));

  assert_flag_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lat_flag |-> strobe_oe);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_err |=> deadline_err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadline_err) |-> $past(overdue));

  assert_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_active |-> $past(!cs_n));
endmodule

bind psram_refresh_sched psram_refresh_sched_chk #(.CA_CYCLES(CA_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .rf_ack       (rf_ack),
  .rf_req       (rf_req),
  .txn_active   (txn_active),
  .strobe_oe    (strobe_oe),
  .lat_flag     (lat_flag),
  .deadline_err (deadline_err),
  .pend         (pend_w),
  .rf_done      (rf_done_w),
  .cs_fall      (cs_fall_w),
  .overdue      (overdue_w)
);

// File: tb/psram_refresh_sched_test.sv
module psram_refresh_sched_test;
  localparam int unsigned INTERVAL  = 20;
  localparam int unsigned CA_CYCLES = 3;
  localparam int unsigned LAT_BASE  = 6;
  localparam int unsigned WAIT_W    = 8;
  localparam int unsigned LW        = $clog2(2 * LAT_BASE + 1);

  // idle cycles, transaction length, acknowledge delay
  localparam int NV = 12;
  localparam int VEC [NV][3] = '{
    '{25, 4, 0}, '{3, 1, 2}, '{7, 2, 1}, '{2, 3, 0},
    '{1, 25, 3}, '{9, 6, 0}, '{4, 12, 2}, '{0, 5, 1},
    '{18, 2, 4}, '{5, 30, 0}, '{1, 1, 1}, '{11, 8, 2}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1;
  logic [WAIT_W-1:0] max_wait = 8'd255;
  logic              rf_ack = 1'b0;
  logic              rf_req, txn_active, strobe_oe, lat_flag, deadline_err;
  logic [LW-1:0]     init_lat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ack_dly = 0;
  int req_age = 0;

  always #10 clk = ~clk;

  psram_refresh_sched #(
    .INTERVAL(INTERVAL), .CA_CYCLES(CA_CYCLES), .LAT_BASE(LAT_BASE), .WAIT_W(WAIT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .max_wait(max_wait), .rf_ack(rf_ack),
    .rf_req(rf_req), .txn_active(txn_active), .strobe_oe(strobe_oe),
    .lat_flag(lat_flag), .init_lat(init_lat), .deadline_err(deadline_err)
  );

  // Behavioural model restated from the requirements.
  int m_since;      // edges since reset, for interval expiry (R2)
  bit m_owed, m_busy, m_prev_cs, m_flagged, m_err;
  int m_window, m_owed_age;

  always @(posedge clk) begin
    bit expiry, opened, acked;
    if (!rst_n) begin
      m_since = 0; m_owed = 0; m_busy = 0; m_prev_cs = 1;
      m_flagged = 0; m_err = 0; m_window = 0; m_owed_age = 0;
    end else begin
      m_since  = m_since + 1;
      expiry   = (m_since % INTERVAL) == 0;
      opened   = m_prev_cs && !cs_n;
      acked    = m_busy && rf_ack;
      if (m_owed && m_owed_age >= int'(max_wait)) m_err = 1;
      m_owed_age = m_owed ? m_owed_age + 1 : 0;
      if (opened) begin
        m_window = CA_CYCLES; m_flagged = m_owed;
      end else if (cs_n) begin
        m_window = 0; m_flagged = 0;
      end else if (m_window > 0) begin
        m_window = m_window - 1;
      end
      if (m_busy) m_busy = !rf_ack;
      else        m_busy = m_owed && cs_n;
      if (expiry)     m_owed = 1;
      else if (acked) m_owed = 0;
      m_prev_cs = cs_n;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 R3 R4 rf_req", int'(rf_req), int'(m_busy));
    check("R9 txn_active", int'(txn_active), int'(!m_prev_cs));
    check("R5 strobe_oe", int'(strobe_oe), int'(m_window > 0));
    check("R6 lat_flag", int'(lat_flag), int'((m_window > 0) && m_flagged));
    check("R7 init_lat", int'(init_lat), m_flagged ? 2 * LAT_BASE : LAT_BASE);
    check("R8 deadline_err", int'(deadline_err), int'(m_err));
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step(input logic csn);
    @(negedge clk);
    compare_all();
    cs_n = csn;
    rf_ack = rf_req && (req_age >= ack_dly);
    req_age = rf_req ? req_age + 1 : 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; rf_ack = 1'b0; req_age = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    check("R1 rf_req", int'(rf_req), 0);
    check("R1 txn_active", int'(txn_active), 0);
    check("R1 strobe_oe", int'(strobe_oe), 0);
    check("R1 lat_flag", int'(lat_flag), 0);
    check("R1 init_lat", int'(init_lat), LAT_BASE);
    check("R1 deadline_err", int'(deadline_err), 0);

    for (int v = 0; v < NV; v++) begin
      ack_dly = VEC[v][2];
      for (int i = 0; i < VEC[v][0]; i++) step(1'b1);
      for (int i = 0; i < VEC[v][1]; i++) step(1'b0);
    end
    for (int i = 0; i < 10; i++) step(1'b1);

    // R8: transaction held far past the deadline with a tight limit
    max_wait = 8'd4;
    ack_dly = 0;
    for (int i = 0; i < 60; i++) step(1'b0);
    @(negedge clk);
    check("R8 deadline_err set", int'(deadline_err), 1);
    for (int i = 0; i < 30; i++) step(1'b1);
    @(negedge clk);
    check("R8 deadline_err sticky", int'(deadline_err), 1);
    check("R4 refresh drained", int'(rf_req), int'(m_busy));

    // R1: reset clears the error
    max_wait = 8'd255;
    do_reset();
    @(negedge clk);
    check("R1 deadline_err after reset", int'(deadline_err), 0);
    for (int i = 0; i < 45; i++) step(i % 9 < 5);
    finish_run();
  end
endmodule